// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a synchronous memory that serves four-word bursts. A burst begins when one of two active-low address strobes is sampled low at a rising clock edge. One strobe is driven by a processor and the other by a cache controller. At that edge the block captures the whole input address. The upper address bits stay fixed for the rest of the burst. The two lowest bits become the start offset of a 2-bit burst counter.

After the start, every clock edge that samples the active-low advance input low moves the counter one step. The order of the steps depends on an order-select input that is sampled at the burst start. A low level gives linear order, which adds the step count to the start offset modulo four. A high level gives interleaved order, which XORs the start offset with the step count. High is also the level to use when the pin is left unconnected. All inputs are sampled on the rising clock edge. The outputs come straight from registers, so each result appears one cycle after the edge that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: When the processor strobe and the primary select are both low at an edge, the next cycle shows `active`=1, `burst_pos`=0 and `addr_out` equal to the address sampled at that edge. This happens whatever the level of the secondary select.
- R2: When the controller strobe is low, the processor strobe does not apply, the primary select is low and the secondary select is high, the block loads the address exactly as in R1.
- R3: When both strobes are low, the processor strobe wins. With the primary select low and the secondary select low, the block still loads the address and raises `active`.
- R4: While the primary select is high, a low processor strobe has no effect. With the controller strobe and advance both high, `addr_out`, `burst_pos` and `active` keep their values.
- R5: A controller strobe with the primary select high or the secondary select low clears `active`, unless a processor strobe applies at the same edge. `addr_out` keeps its value.
- R6: With `order_ilv`=0 captured, the low two bits of `addr_out` follow (start + k) mod 4, where k is `burst_pos`.
- R7: With `order_ilv`=1 captured, the low two bits of `addr_out` follow start XOR k.
- R8: When no strobe applies and `adv_n` is high, `addr_out` and `burst_pos` hold their values.
- R9: When `active`=1, no strobe applies and `adv_n` is low, `burst_pos` increments modulo 4. After the fourth address it wraps back to the start offset.
- R10: The bits of `addr_out` above bit 1 change only at an edge where a load occurs.
- R11: The order is captured at the burst start. Changing `order_ilv` in the middle of a burst does not change the sequence.
- R12: While `active`=0, `adv_n` low has no effect: `burst_pos` holds and `active` stays low.
- R13: After reset, `active`=0, `burst_pos`=0 and `addr_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | Address sampled when a burst starts |
| strobe_proc_n | input | 1 | Processor-side burst-start strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| order_ilv | input | 1 | Burst order: 1 interleaved (default), 0 linear |
| addr_out | output | ADDR_W | Current burst address |
| burst_pos | output | 2 | Number of steps taken since the burst start |
| active | output | 1 | A burst is selected and in progress |

## Verification
The linear and interleaved orders are each run from several start offsets. The sequences are continued past four advances, so the wrap back to the start offset is checked separately from a plain modulo count. Advance is held off partway through bursts and the order input is toggled mid-burst, which separates the stepping logic from the capture of the order. The strobes are tried in each mix of select levels: processor only, controller only, both at once, and each with a select off. These cases show priority, the ignore rule and deselection. Advance pulses are also given while the block is deselected.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes a fixed four-beat burst, so the burst offset is two bits wide.
package burst_seq_pkg;
    localparam int OFS_W = 2;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_DESEL = 2'd2,
        ACT_STEP  = 2'd3
    } seq_act_t;
endpackage

// File: rtl/burst_strobe_arbiter.sv
// Decides what the sequencer does at each edge, based on the strobes,
// the selects and advance. The processor strobe needs only the primary
// select and wins over the controller strobe. The controller strobe needs
// both selects; without them it deselects the block.
// Assumes that all inputs are already synchronous to the clock.
module burst_strobe_arbiter
    import burst_seq_pkg::*;
(
    input  logic     strobe_proc_n,
    input  logic     strobe_ctrl_n,
    input  logic     adv_n,
    input  logic     sel_n,
    input  logic     sel_hi,
    input  logic     active,
    output seq_act_t act
);
    logic proc_take;
    logic ctrl_take;

    // Qualifies each strobe with the selects it depends on.
    always_comb begin
        proc_take = !strobe_proc_n && !sel_n;
        ctrl_take = !strobe_ctrl_n && !sel_n && sel_hi;
    end

    // Chooses one action, in priority order.
    always_comb begin
        act = ACT_HOLD;
        if (proc_take) begin
            act = ACT_LOAD;
        end else if (!strobe_ctrl_n) begin
            act = ctrl_take ? ACT_LOAD : ACT_DESEL;
        end else if (active && !adv_n) begin
            act = ACT_STEP;
        end
    end
endmodule

// File: rtl/burst_step_counter.sv
// Holds the burst state: start offset, step count, captured order and the
// active flag. A load seeds the start offset from the low address bits and
// clears the step count. A step adds one modulo the burst length.
// Assumes that act comes from burst_strobe_arbiter.
module burst_step_counter
    import burst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  seq_act_t act,
    input  ofs_t     start_in,
    input  logic     order_in,
    output ofs_t     start_q,
    output ofs_t     step_q,
    output logic     order_q,
    output logic     active_q
);
    // Updates the burst state at each edge; reset selects interleaved order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            step_q   <= '0;
            order_q  <= 1'b1;
            active_q <= 1'b0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    start_q  <= start_in;
                    step_q   <= '0;
                    order_q  <= order_in;
                    active_q <= 1'b1;
                end
                ACT_DESEL: active_q <= 1'b0;
                ACT_STEP:  step_q   <= step_q + ofs_t'(1);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/burst_order_map.sv
// Turns the start offset and step count into the current offset.
// Linear order adds them modulo the burst length; interleaved order XORs them.
// Purely combinational.
module burst_order_map
    import burst_seq_pkg::*;
(
    input  ofs_t start_q,
    input  ofs_t step_q,
    input  logic order_q,
    output ofs_t ofs
);
    // Chooses the ordering rule given by the captured order bit.
    always_comb begin
        if (order_q) ofs = start_q ^ step_q;
        else         ofs = start_q + step_q;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Top level of the burst address sequencer. It registers the upper address
// bits at each load and joins them with the mapped burst offset.
// Assumes ADDR_W is larger than the offset width.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctrl_n,
    input  logic              adv_n,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        burst_pos,
    output logic              active
);
    localparam int HI_W = ADDR_W - OFS_W;

    seq_act_t        act;
    ofs_t            start_q;
    ofs_t            step_q;
    ofs_t            ofs;
    logic            order_q;
    logic            active_q;
    logic [HI_W-1:0] base_q;

    burst_strobe_arbiter u_arb (
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .adv_n         (adv_n),
        .sel_n         (sel_n),
        .sel_hi        (sel_hi),
        .active        (active_q),
        .act           (act)
    );

    burst_step_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .start_in (addr_in[OFS_W-1:0]),
        .order_in (order_ilv),
        .start_q  (start_q),
        .step_q   (step_q),
        .order_q  (order_q),
        .active_q (active_q)
    );

    burst_order_map u_map (
        .start_q (start_q),
        .step_q  (step_q),
        .order_q (order_q),
        .ofs     (ofs)
    );

    // Captures the upper address bits, which stay fixed for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n)              base_q <= '0;
        else if (act == ACT_LOAD) base_q <= addr_in[ADDR_W-1:OFS_W];
    end

    // Drives the outputs from the registered state.
    always_comb begin
        addr_out  = {base_q, ofs};
        burst_pos = step_q;
        active    = active_q;
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Checks the burst address sequencer at its ports. Attached by bind below.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_proc_n,
    input logic              strobe_ctrl_n,
    input logic              adv_n,
    input logic              sel_n,
    input logic              sel_hi,
    input logic              order_ilv,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        burst_pos,
    input logic              active
);
    logic no_proc;
    logic no_strobe;

    // Marks the edges where no strobe applies.
    always_comb begin
        no_proc   = strobe_proc_n || sel_n;
        no_strobe = no_proc && strobe_ctrl_n;
    end

    AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_proc) |=> (active && burst_pos == 2'd0 && addr_out == $past(addr_in))); // R1
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (no_proc && !strobe_ctrl_n && !sel_n && sel_hi)
        |=> (active && burst_pos == 2'd0 && addr_out == $past(addr_in))); // R2
    AST_PROC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && !strobe_ctrl_n && !sel_n && !sel_hi) |=> active); // R3
    AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && sel_n && strobe_ctrl_n && adv_n)
        |=> ($stable(addr_out) && $stable(active) && $stable(burst_pos))); // R4
    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (no_proc && !strobe_ctrl_n && (sel_n || !sel_hi))
        |=> (!active && $stable(addr_out))); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && adv_n) |=> ($stable(addr_out) && $stable(burst_pos))); // R8
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !adv_n && active)
        |=> (burst_pos == 2'($past(burst_pos) + 2'd1))); // R9
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        no_strobe |=> $stable(addr_out[ADDR_W-1:2])); // R10
    AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !active) |=> (!active && $stable(burst_pos))); // R12
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
    localparam int ADDR_W = 20;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        pos;
        logic              act;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              strobe_proc_n = 1'b1;
    logic              strobe_ctrl_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              sel_n = 1'b1;
    logic              sel_hi = 1'b0;
    logic              order_ilv = 1'b1;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        burst_pos;
    logic              active;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;
    exp_t sb[$];

    // reference model state
    logic [ADDR_W-3:0] m_base = '0;
    logic [1:0]        m_start = '0;
    logic [1:0]        m_step = '0;
    logic              m_ilv = 1'b1;
    logic              m_act = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (.*);

    function automatic exp_t predict(string req);
        exp_t e;
        logic [1:0] o;
        o = m_ilv ? (m_start ^ m_step) : 2'(m_start + m_step);
        e.addr = {m_base, o};
        e.pos  = m_step;
        e.act  = m_act;
        e.req  = req;
        return e;
    endfunction

    // one clock of stimulus, model update, and an expected item pushed
    task automatic cyc(input logic p_n, input logic c_n, input logic a_n,
                       input logic s_n, input logic s_hi, input logic ilv,
                       input logic [ADDR_W-1:0] a, input string req);
        @(negedge clk);
        strobe_proc_n = p_n; strobe_ctrl_n = c_n; adv_n = a_n;
        sel_n = s_n; sel_hi = s_hi; order_ilv = ilv; addr_in = a;
        @(posedge clk);
        if (!p_n && !s_n) begin
            m_base = a[ADDR_W-1:2]; m_start = a[1:0]; m_step = 2'd0;
            m_ilv = ilv; m_act = 1'b1;
        end else if (!c_n) begin
            if (!s_n && s_hi) begin
                m_base = a[ADDR_W-1:2]; m_start = a[1:0]; m_step = 2'd0;
                m_ilv = ilv; m_act = 1'b1;
            end else begin
                m_act = 1'b0;
            end
        end else if (m_act && !a_n) begin
            m_step = 2'(m_step + 2'd1);
        end
        #1;
        sb.push_back(predict(req));
    endtask

    // monitor: compares each expected item once the outputs have settled
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (addr_out !== e.addr || burst_pos !== e.pos || active !== e.act) begin
                n_bad++;
                $display("FAIL %s: addr=%h pos=%0d act=%0b expected addr=%h pos=%0d act=%0b",
                         e.req, addr_out, burst_pos, active, e.addr, e.pos, e.act);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state with no strobe
        cyc(1, 1, 1, 1, 0, 1, 20'hFFFFF, "R13");
        // R12: advance while idle is ignored
        cyc(1, 1, 0, 0, 1, 1, 20'h0, "R12");
        // R1 + R6 + R9: processor start, linear, offset 1, six advances
        cyc(0, 1, 1, 0, 0, 0, 20'hABC41, "R1");
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 1, 0, 20'h0, "R6_R9");
        // R8: hold with advance off
        cyc(1, 1, 1, 0, 1, 0, 20'h12345, "R8");
        cyc(1, 1, 1, 0, 1, 0, 20'h12345, "R8");
        // R2 + R7 + R9: controller start, interleaved, offset 2
        cyc(1, 0, 1, 0, 1, 1, 20'h5A5A6, "R2");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 1, 1, 20'h0, "R7_R9");
        // R7: interleaved from offset 3
        cyc(0, 1, 1, 0, 1, 1, 20'h00F0F, "R7");
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 1, 1, 20'h0, "R7");
        // R11: order toggled mid-burst (captured linear, offset 3)
        cyc(0, 1, 1, 0, 1, 0, 20'h33333, "R11");
        cyc(1, 1, 0, 0, 1, 1, 20'h0, "R11");
        cyc(1, 1, 0, 0, 1, 1, 20'h0, "R11");
        cyc(1, 1, 0, 0, 1, 0, 20'h0, "R11");
        // R4: processor strobe with primary select off is ignored
        cyc(0, 1, 1, 1, 1, 1, 20'hEEEE0, "R4");
        cyc(0, 1, 1, 1, 0, 0, 20'h11112, "R4");
        // R10: upper bits fixed while stepping with a changing address input
        cyc(1, 1, 0, 0, 1, 0, 20'hFFFFF, "R10");
        // R5: controller strobe with secondary select low deselects
        cyc(1, 0, 1, 0, 0, 1, 20'h77777, "R5");
        // R12: advance while deselected does nothing
        cyc(1, 1, 0, 0, 1, 1, 20'h0, "R12");
        cyc(1, 1, 0, 0, 1, 1, 20'h0, "R12");
        // R3: both strobes, secondary select low: processor wins
        cyc(0, 0, 1, 0, 0, 0, 20'h2468A, "R3");
        cyc(1, 1, 0, 0, 0, 0, 20'h0, "R3");
        // R5: controller strobe with primary select high deselects
        cyc(1, 0, 0, 1, 1, 1, 20'h13579, "R5");
        // R4 with R5 state: both strobes, primary off -> controller deselect path
        cyc(0, 0, 1, 1, 1, 1, 20'h9999B, "R4_R5");
        // R1: processor start ignores secondary select, offset 0 linear
        cyc(0, 1, 1, 0, 0, 0, 20'hC0DE0, "R1");
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 20'h0, "R6_R9");
        // R2: controller start, offset 1 interleaved
        cyc(1, 0, 1, 0, 1, 1, 20'h00001, "R2");
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 1, 1, 20'h0, "R7");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule